// File: doc/BRIEF.md
# AXI4-Lite Configurable Register Bank

This block is an AXI4-Lite slave that presents a small, fixed map of 32-bit registers to a host processor. Each word has one access mode. Read-only words carry values produced by user logic. Write-only words carry commands from the host. Read-write words carry configuration that the host can read back. The map has five kinds of word:

- a read-only status word, which raises a read strobe;
- a write-only command word, which raises a write strobe;
- a read-write configuration word with a non-zero reset value, which raises both strobes;
- a packed control word holding three narrow fields;
- two wide values, one read-only and one read-write, each spread over consecutive word addresses.

All offsets are relative to the `BASE_ADDR` parameter.

The write-address and write-data channels are taken independently, in either order, and a single write response is returned once both have arrived. Byte-lane strobes select which bytes of a word change. An address that no register covers gets an error response, and the block's state does not change. When `CDC_EN` is set, the block moves values between two clocks. Host-driven values cross into the module clock, and user-driven read-only values cross into the bus clock, through `SYNC_STAGES` flip-flops in each direction. Strobes always stay in the bus clock domain.

Top module: `axil_regbank`

## Requirements
- R1: After reset, the register values are as follows. The configuration word (offset 0x08) reads 0x0000CAFE. The control word (0x0C) reads 0x00000001, which is enable=1, mode=0, mask=0. The command word and the wide read-write value are zero. The module-domain outputs show these same values.
- R2: The status word at offset 0x00 reads the value on `status_in`. A host write to it returns OKAY (bresp 2'b00) and changes nothing.
- R3: The command word at offset 0x04 drives `cmd_out`. A read of it returns zero with OKAY.
- R4: The configuration word at offset 0x08 reads back the last value written to it. Only the bytes whose `s_wstrb` bit is set are changed (bit n selects bits 8n+7:8n). Byte-lane merging also applies to the command, control and wide read-write words.
- R5: A write strobe pulses for one bus cycle, in the cycle in which `s_bvalid` rises. `cmd_wstb` pulses on writes to 0x04 and `cfg_wstb` on writes to 0x08. A read strobe pulses for one cycle, in the cycle in which `s_rvalid` rises. `cfg_rstb` pulses on reads of 0x08 and `status_rstb` on reads of 0x00. No other address pulses any strobe.
- R6: The control word at offset 0x0C packs three fields: enable at bit 0, mode at bits 2:1 and mask at bits 7:4. Bit 3 and bits 31:8 always read zero, and writes to them are ignored.
- R7: Each wide value of `WIDE_W` bits occupies consecutive words, least significant word first. The read-only value from `wide_in` starts at offset 0x10, so with 64 bits it uses 0x10 and 0x14. The read-write value on `wide_out` follows it, at 0x18 and 0x1C for 64 bits.
- R8: A bus address is decoded as `BASE_ADDR` plus an offset. Any of the following gets an SLVERR response (2'b10), and reads of such addresses return zero data:
  - an address below `BASE_ADDR`;
  - an offset at or above 0x10000;
  - an offset that is not a multiple of 4;
  - an offset past the last mapped word.
  A write that gets SLVERR changes no register.
- R9: The write-address and write-data channels are accepted independently, in either order or in the same cycle. `s_bvalid` is not raised until both have been accepted.
- R10: `s_bvalid` is held, with a stable `s_bresp`, until `s_bready` is seen. `s_rvalid` is held, with stable `s_rdata` and `s_rresp`, until `s_rready` is seen. Each channel holds at most one outstanding transfer.
- R11: With `CDC_EN` set, a host-written value reaches its module-domain output only after `SYNC_STAGES` module-clock edges, and a new `status_in` value reaches bus reads only after `SYNC_STAGES` bus-clock edges. Once synchronized, both are exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| mod_clk | input | 1 | Module clock |
| mod_rst | input | 1 | Synchronous active-high reset, module domain |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte-lane strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| status_in | input | 32 | Read-only status from user logic (module domain) |
| wide_in | input | WIDE_W | Wide read-only value from user logic (module domain) |
| cmd_out | output | 32 | Command word (module domain) |
| cfg_out | output | 32 | Configuration word (module domain) |
| ctl_en | output | 1 | Control enable field (module domain) |
| ctl_mode | output | 2 | Control mode field (module domain) |
| ctl_mask | output | 4 | Control mask field (module domain) |
| wide_out | output | WIDE_W | Wide read-write value (module domain) |
| cmd_wstb | output | 1 | Write strobe for the command word (bus domain) |
| cfg_wstb | output | 1 | Write strobe for the configuration word (bus domain) |
| cfg_rstb | output | 1 | Read strobe for the configuration word (bus domain) |
| status_rstb | output | 1 | Read strobe for the status word (bus domain) |

## Verification
The bench sweeps every word offset, and the mapped range ends with a few unmapped words. It compares each read with a map computed independently in the bench from the writes made so far. It tries the following corner cases:

- **Channel order.** Writes present the address first, the data first, or both at once. A decoder that waited for one fixed order would hang. One that answered before both channels had arrived would show `s_bvalid` early.
- **Partial strobes and reserved bits.** Partial byte strobes catch a block that writes the whole word. Writing all ones to the packed control word catches reserved bits that are kept or read back.
- **Rejected addresses.** The bench writes below the base, past the map, to an offset at or above 0x10000 and to an unaligned offset, then sweeps again. A decoder that ignored the base or the alignment would corrupt registers or answer OKAY.
- **Crossing latency.** The bench checks that a newly written value is not yet visible in the module domain when the response finishes. This exposes a crossing that was skipped or made too short.

// File: rtl/axil_regbank_pkg.sv
package axil_regbank_pkg;

  localparam int DATA_W = 32;
  localparam int STRB_W = DATA_W / 8;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  // Word indices (byte offset / 4) of the fixed map
  localparam logic [13:0] WORD_STATUS = 14'd0;
  localparam logic [13:0] WORD_CMD    = 14'd1;
  localparam logic [13:0] WORD_CFG    = 14'd2;
  localparam logic [13:0] WORD_CTL    = 14'd3;
  localparam logic [13:0] WORD_WIDE0  = 14'd4;

  // Packed control word layout
  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_MODE_LSB = 1;
  localparam int CTL_MODE_W   = 2;
  localparam int CTL_MASK_LSB = 4;
  localparam int CTL_MASK_W   = 4;
  localparam int CTL_BITS     = 1 + CTL_MODE_W + CTL_MASK_W;

  // Merge new data into an old word byte lane by byte lane
  function automatic logic [DATA_W-1:0] lane_merge(input logic [DATA_W-1:0] old_w,
                                                   input logic [DATA_W-1:0] new_w,
                                                   input logic [STRB_W-1:0] strb);
    logic [DATA_W-1:0] res;
    res = old_w;
    for (int b = 0; b < STRB_W; b++) begin
      if (strb[b]) res[b*8 +: 8] = new_w[b*8 +: 8];
    end
    return res;
  endfunction

endpackage

// File: rtl/axil_regbank_sync.sv
module axil_regbank_sync #(
  parameter int              W       = 8,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];
  logic [2:0]   settle;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

  // Cycles since reset, saturating at the stage count (used by the check only)
  always_ff @(posedge clk) begin
    if (rst)                        settle <= '0;
    else if (settle != 3'(STAGES))  settle <= settle + 3'd1;
  end

  assert_sync_latency_R11: assert property (@(posedge clk) disable iff (rst)
    (settle == 3'(STAGES)) |-> (q == $past(d, STAGES)));

endmodule

// File: rtl/axil_regbank_if.sv
module axil_regbank_if
  import axil_regbank_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [STRB_W-1:0] wr_strb,
  input  logic              wr_err,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_err
);

  logic              aw_full, w_full;
  logic [ADDR_W-1:0] aw_q;
  logic [DATA_W-1:0] w_q;
  logic [STRB_W-1:0] strb_q;
  logic              bvalid_q, rvalid_q;
  logic [1:0]        bresp_q, rresp_q;
  logic [DATA_W-1:0] rdata_q;

  // Write side: one holding slot per channel, commit once both are full
  assign s_awready = !aw_full;
  assign s_wready  = !w_full;
  assign wr_en     = aw_full && w_full && !bvalid_q;
  assign wr_addr   = aw_q;
  assign wr_data   = w_q;
  assign wr_strb   = strb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_full  <= 1'b0;
      w_full   <= 1'b0;
      aw_q     <= '0;
      w_q      <= '0;
      strb_q   <= '0;
      bvalid_q <= 1'b0;
      bresp_q  <= RESP_OKAY;
    end else begin
      if (s_awvalid && s_awready) begin
        aw_full <= 1'b1;
        aw_q    <= s_awaddr;
      end
      if (s_wvalid && s_wready) begin
        w_full <= 1'b1;
        w_q    <= s_wdata;
        strb_q <= s_wstrb;
      end
      if (wr_en) begin
        aw_full  <= 1'b0;
        w_full   <= 1'b0;
        bvalid_q <= 1'b1;
        bresp_q  <= wr_err ? RESP_SLVERR : RESP_OKAY;
      end else if (bvalid_q && s_bready) begin
        bvalid_q <= 1'b0;
      end
    end
  end

  assign s_bvalid = bvalid_q;
  assign s_bresp  = bresp_q;

  // Read side: single-cycle decode, one read in flight
  assign s_arready = !rvalid_q;
  assign rd_en     = s_arvalid && s_arready;
  assign rd_addr   = s_araddr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
      rresp_q  <= RESP_OKAY;
    end else if (rd_en) begin
      rvalid_q <= 1'b1;
      rdata_q  <= rd_data;
      rresp_q  <= rd_err ? RESP_SLVERR : RESP_OKAY;
    end else if (rvalid_q && s_rready) begin
      rvalid_q <= 1'b0;
    end
  end

  assign s_rvalid = rvalid_q;
  assign s_rdata  = rdata_q;
  assign s_rresp  = rresp_q;

  assert_bresp_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bresp)));

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata) && $stable(s_rresp)));

  assert_err_data_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (s_rvalid && s_rresp == RESP_SLVERR) |-> (s_rdata == '0));

  assert_resp_after_both_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(s_bvalid) |-> ($past(!s_awready) && $past(!s_wready)));

endmodule

// File: rtl/axil_regbank_regs.sv
module axil_regbank_regs
  import axil_regbank_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = '0,
  parameter int                WIDE_W     = 64,
  parameter logic [DATA_W-1:0] CFG_RESET  = 32'h0000_CAFE,
  parameter logic              CTL_EN_RST = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [STRB_W-1:0]     wr_strb,
  output logic                  wr_err,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  rd_err,
  input  logic [DATA_W-1:0]     status_i,
  input  logic [WIDE_W-1:0]     wide_i,
  output logic [DATA_W-1:0]     cmd_q,
  output logic [DATA_W-1:0]     cfg_q,
  output logic                  ctl_en,
  output logic [CTL_MODE_W-1:0] ctl_mode,
  output logic [CTL_MASK_W-1:0] ctl_mask,
  output logic [WIDE_W-1:0]     wide_q,
  output logic                  cmd_wstb,
  output logic                  cfg_wstb,
  output logic                  cfg_rstb,
  output logic                  status_rstb
);

  localparam int          WORDS     = WIDE_W / DATA_W;
  localparam logic [13:0] WORD_WIN  = WORD_WIDE0;
  localparam logic [13:0] WORD_WOUT = WORD_WIDE0 + 14'(WORDS);
  localparam logic [13:0] WORD_END  = WORD_WOUT + 14'(WORDS);

  // {hit, word index}
  function automatic logic [14:0] decode(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] off;
    logic              ok;
    off = a - BASE_ADDR;
    ok  = (off[ADDR_W-1:16] == '0) && (off[1:0] == 2'b00) && (off[15:2] < WORD_END);
    return {ok, off[15:2]};
  endfunction

  logic [14:0] wdec, rdec;
  logic        whit, rhit;
  logic [13:0] wword, rword;
  logic [DATA_W-1:0] ctl_word;

  assign wdec  = decode(wr_addr);
  assign rdec  = decode(rd_addr);
  assign whit  = wdec[14];
  assign wword = wdec[13:0];
  assign rhit  = rdec[14];
  assign rword = rdec[13:0];
  assign wr_err = !whit;

  always_comb begin
    ctl_word = '0;
    ctl_word[CTL_EN_BIT] = ctl_en;
    ctl_word[CTL_MODE_LSB +: CTL_MODE_W] = ctl_mode;
    ctl_word[CTL_MASK_LSB +: CTL_MASK_W] = ctl_mask;
  end

  // Host-writable storage
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= '0;
      cfg_q    <= CFG_RESET;
      ctl_en   <= CTL_EN_RST;
      ctl_mode <= '0;
      ctl_mask <= '0;
      wide_q   <= '0;
    end else if (wr_en && whit) begin
      if (wword == WORD_CMD) cmd_q <= lane_merge(cmd_q, wr_data, wr_strb);
      if (wword == WORD_CFG) cfg_q <= lane_merge(cfg_q, wr_data, wr_strb);
      if (wword == WORD_CTL) begin
        ctl_en   <= lane_merge(ctl_word, wr_data, wr_strb)[CTL_EN_BIT];
        ctl_mode <= lane_merge(ctl_word, wr_data, wr_strb)[CTL_MODE_LSB +: CTL_MODE_W];
        ctl_mask <= lane_merge(ctl_word, wr_data, wr_strb)[CTL_MASK_LSB +: CTL_MASK_W];
      end
      for (int k = 0; k < WORDS; k++) begin
        if (wword == WORD_WOUT + 14'(k))
          wide_q[k*DATA_W +: DATA_W] <= lane_merge(wide_q[k*DATA_W +: DATA_W], wr_data, wr_strb);
      end
    end
  end

  // Read multiplexer
  always_comb begin
    rd_data = '0;
    rd_err  = !rhit;
    if (rhit) begin
      if (rword == WORD_STATUS)                        rd_data = status_i;
      else if (rword == WORD_CFG)                      rd_data = cfg_q;
      else if (rword == WORD_CTL)                      rd_data = ctl_word;
      else if (rword >= WORD_WIN && rword < WORD_WOUT) rd_data = wide_i[int'(rword - WORD_WIN)*DATA_W +: DATA_W];
      else if (rword >= WORD_WOUT)                     rd_data = wide_q[int'(rword - WORD_WOUT)*DATA_W +: DATA_W];
    end
  end

  // One-cycle strobes, registered alongside the response
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_wstb    <= 1'b0;
      cfg_wstb    <= 1'b0;
      cfg_rstb    <= 1'b0;
      status_rstb <= 1'b0;
    end else begin
      cmd_wstb    <= wr_en && whit && (wword == WORD_CMD);
      cfg_wstb    <= wr_en && whit && (wword == WORD_CFG);
      cfg_rstb    <= rd_en && rhit && (rword == WORD_CFG);
      status_rstb <= rd_en && rhit && (rword == WORD_STATUS);
    end
  end

  assert_bad_write_inert_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_err) |=> ($stable(cmd_q) && $stable(cfg_q) && $stable(wide_q) &&
                           $stable(ctl_en) && $stable(ctl_mode) && $stable(ctl_mask)));

  assert_ro_write_inert_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_err && wword == WORD_STATUS) |=> ($stable(cmd_q) && $stable(cfg_q) &&
                           $stable(wide_q) && $stable(ctl_en) && $stable(ctl_mode) && $stable(ctl_mask)));

endmodule

// File: rtl/axil_regbank.sv
module axil_regbank
  import axil_regbank_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = '0,
  parameter int                WIDE_W      = 64,
  parameter logic [31:0]       CFG_RESET   = 32'h0000_CAFE,
  parameter logic              CTL_EN_RST  = 1'b1,
  parameter bit                CDC_EN      = 1'b1,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mod_clk,
  input  logic              mod_rst,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic [3:0]        s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  input  logic [31:0]       status_in,
  input  logic [WIDE_W-1:0] wide_in,
  output logic [31:0]       cmd_out,
  output logic [31:0]       cfg_out,
  output logic              ctl_en,
  output logic [1:0]        ctl_mode,
  output logic [3:0]        ctl_mask,
  output logic [WIDE_W-1:0] wide_out,
  output logic              cmd_wstb,
  output logic              cfg_wstb,
  output logic              cfg_rstb,
  output logic              status_rstb
);

  localparam int IN_W  = DATA_W + WIDE_W;
  localparam int OUT_W = 2*DATA_W + CTL_BITS + WIDE_W;
  localparam logic [OUT_W-1:0] OUT_RST =
    {{WIDE_W{1'b0}}, {CTL_MASK_W{1'b0}}, {CTL_MODE_W{1'b0}}, CTL_EN_RST, CFG_RESET, {DATA_W{1'b0}}};

  logic              wr_en, wr_err, rd_en, rd_err;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [STRB_W-1:0] wr_strb;

  logic [DATA_W-1:0]     status_b, cmd_b, cfg_b;
  logic [WIDE_W-1:0]     wide_in_b, wide_b;
  logic                  en_b;
  logic [CTL_MODE_W-1:0] mode_b;
  logic [CTL_MASK_W-1:0] mask_b;
  logic [IN_W-1:0]       in_bus;
  logic [OUT_W-1:0]      out_bus, out_mod;

  axil_regbank_if #(.ADDR_W(ADDR_W)) u_if (
    .clk(clk), .rst(rst),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb), .wr_err(wr_err),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_err(rd_err)
  );

  axil_regbank_regs #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .WIDE_W(WIDE_W),
    .CFG_RESET(CFG_RESET), .CTL_EN_RST(CTL_EN_RST)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb), .wr_err(wr_err),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_err(rd_err),
    .status_i(status_b), .wide_i(wide_in_b),
    .cmd_q(cmd_b), .cfg_q(cfg_b), .ctl_en(en_b), .ctl_mode(mode_b), .ctl_mask(mask_b),
    .wide_q(wide_b),
    .cmd_wstb(cmd_wstb), .cfg_wstb(cfg_wstb), .cfg_rstb(cfg_rstb), .status_rstb(status_rstb)
  );

  assign out_bus = {wide_b, mask_b, mode_b, en_b, cfg_b, cmd_b};

  generate
    if (CDC_EN) begin : g_cdc
      axil_regbank_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_in (
        .clk(clk), .rst(rst), .d({wide_in, status_in}), .q(in_bus)
      );
      axil_regbank_sync #(.W(OUT_W), .STAGES(SYNC_STAGES), .RST_VAL(OUT_RST)) u_sync_out (
        .clk(mod_clk), .rst(mod_rst), .d(out_bus), .q(out_mod)
      );
    end else begin : g_direct
      assign in_bus  = {wide_in, status_in};
      assign out_mod = out_bus;
    end
  endgenerate

  assign status_b  = in_bus[DATA_W-1:0];
  assign wide_in_b = in_bus[IN_W-1:DATA_W];
  assign cmd_out   = out_mod[DATA_W-1:0];
  assign cfg_out   = out_mod[2*DATA_W-1:DATA_W];
  assign ctl_en    = out_mod[2*DATA_W];
  assign ctl_mode  = out_mod[2*DATA_W+1 +: CTL_MODE_W];
  assign ctl_mask  = out_mod[2*DATA_W+1+CTL_MODE_W +: CTL_MASK_W];
  assign wide_out  = out_mod[OUT_W-1 -: WIDE_W];

  assert_wstb_with_resp_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_wstb || cfg_wstb) |-> (s_bvalid && !(cmd_wstb && cfg_wstb)));

  assert_rstb_with_rdata_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg_rstb || status_rstb) |-> $rose(s_rvalid));

endmodule

// File: tb/tb_axil_regbank.sv
module tb_axil_regbank;

  localparam int          ADDR_W = 32;
  localparam int          WIDE_W = 64;
  localparam logic [31:0] BASE   = 32'h0000_1000;

  logic clk = 1'b0, mod_clk = 1'b0, rst = 1'b1, mod_rst = 1'b1;
  always #2   clk     = ~clk;
  always #3.5 mod_clk = ~mod_clk;

  logic [31:0] s_awaddr = '0, s_wdata = '0, s_araddr = '0;
  logic [3:0]  s_wstrb = '0;
  logic s_awvalid = 0, s_wvalid = 0, s_bready = 0, s_arvalid = 0, s_rready = 0;
  logic s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0]  s_bresp, s_rresp;
  logic [31:0] s_rdata;
  logic [31:0] status_in = '0;
  logic [63:0] wide_in = '0;
  logic [31:0] cmd_out, cfg_out;
  logic        ctl_en;
  logic [1:0]  ctl_mode;
  logic [3:0]  ctl_mask;
  logic [63:0] wide_out;
  logic        cmd_wstb, cfg_wstb, cfg_rstb, status_rstb;

  axil_regbank #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE), .WIDE_W(WIDE_W), .CDC_EN(1'b1), .SYNC_STAGES(3)
  ) dut (
    .clk(clk), .rst(rst), .mod_clk(mod_clk), .mod_rst(mod_rst),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .status_in(status_in), .wide_in(wide_in),
    .cmd_out(cmd_out), .cfg_out(cfg_out), .ctl_en(ctl_en), .ctl_mode(ctl_mode),
    .ctl_mask(ctl_mask), .wide_out(wide_out),
    .cmd_wstb(cmd_wstb), .cfg_wstb(cfg_wstb), .cfg_rstb(cfg_rstb), .status_rstb(status_rstb)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // Bench mirror of the register map
  logic [31:0] m_status, m_cmd, m_cfg, m_ctl;
  logic [63:0] m_win, m_wout;

  // Strobe samples from the last transfer
  logic w_cmd1, w_cfg1, w_cmd2, w_cfg2, r_cfg1, r_st1, r_cfg2, r_st2;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n, input logic [3:0] s);
    logic [31:0] r;
    r = o;
    for (int b = 0; b < 4; b++) if (s[b]) r[b*8 +: 8] = n[b*8 +: 8];
    return r;
  endfunction

  function automatic void exp_read(input logic [31:0] off, output logic [31:0] d, output bit err);
    d = '0; err = 1'b0;
    if (off[1:0] != 0 || off >= 32'h20) err = 1'b1;
    else case (off[4:2])
      3'd0: d = m_status;
      3'd1: d = '0;
      3'd2: d = m_cfg;
      3'd3: d = m_ctl;
      3'd4: d = m_win[31:0];
      3'd5: d = m_win[63:32];
      3'd6: d = m_wout[31:0];
      default: d = m_wout[63:32];
    endcase
  endfunction

  function automatic void apply_write(input logic [31:0] off, input logic [31:0] d, input logic [3:0] s);
    if (off[1:0] == 0 && off < 32'h20) begin
      case (off[4:2])
        3'd1: m_cmd = mrg(m_cmd, d, s);
        3'd2: m_cfg = mrg(m_cfg, d, s);
        3'd3: m_ctl = mrg(m_ctl, d, s) & 32'h0000_00F7;
        3'd6: m_wout[31:0]  = mrg(m_wout[31:0], d, s);
        3'd7: m_wout[63:32] = mrg(m_wout[63:32], d, s);
        default: ;
      endcase
    end
  endfunction

  task automatic send_aw();
    s_awvalid = 1'b1;
    while (!s_awready) @(negedge clk);
    @(negedge clk);
    s_awvalid = 1'b0;
  endtask

  task automatic send_w();
    s_wvalid = 1'b1;
    while (!s_wready) @(negedge clk);
    @(negedge clk);
    s_wvalid = 1'b0;
  endtask

  // order: 0 address first, 1 data first, 2 both together
  task automatic do_write(input logic [31:0] addr, input logic [31:0] data, input logic [3:0] strb,
                          input int order, output logic [1:0] resp);
    logic [1:0] r0;
    s_awaddr = addr; s_wdata = data; s_wstrb = strb;
    if (order == 0) begin
      send_aw();
      repeat (3) @(negedge clk);
      chk(!s_bvalid, "R9 no response before data", 64'(s_bvalid), 0);
      send_w();
    end else if (order == 1) begin
      send_w();
      repeat (3) @(negedge clk);
      chk(!s_bvalid, "R9 no response before address", 64'(s_bvalid), 0);
      send_aw();
    end else begin
      bit aw_d = 0, w_d = 0;
      s_awvalid = 1'b1; s_wvalid = 1'b1;
      while (!(aw_d && w_d)) begin
        if (s_awvalid && s_awready) aw_d = 1;
        if (s_wvalid && s_wready) w_d = 1;
        @(negedge clk);
        if (aw_d) s_awvalid = 1'b0;
        if (w_d)  s_wvalid  = 1'b0;
      end
    end
    while (!s_bvalid) @(negedge clk);
    resp = s_bresp; r0 = s_bresp;
    w_cmd1 = cmd_wstb; w_cfg1 = cfg_wstb;
    @(negedge clk);
    w_cmd2 = cmd_wstb; w_cfg2 = cfg_wstb;
    chk(s_bvalid && s_bresp == r0, "R10 bvalid/bresp held", {s_bvalid, s_bresp}, {1'b1, r0});
    s_bready = 1'b1;
    @(negedge clk);
    s_bready = 1'b0;
    chk(!s_bvalid, "R10 bvalid drops after bready", 64'(s_bvalid), 0);
  endtask

  task automatic do_read(input logic [31:0] addr, output logic [31:0] data, output logic [1:0] resp);
    s_araddr = addr;
    s_arvalid = 1'b1;
    while (!s_arready) @(negedge clk);
    @(negedge clk);
    s_arvalid = 1'b0;
    data = s_rdata; resp = s_rresp;
    r_cfg1 = cfg_rstb; r_st1 = status_rstb;
    @(negedge clk);
    r_cfg2 = cfg_rstb; r_st2 = status_rstb;
    chk(s_rvalid && s_rdata == data && s_rresp == resp, "R10 rvalid/rdata held",
        {s_rvalid, s_rresp, s_rdata}, {1'b1, resp, data});
    s_rready = 1'b1;
    @(negedge clk);
    s_rready = 1'b0;
  endtask

  task automatic sweep(input string tag);
    logic [31:0] d, ed;
    logic [1:0]  r;
    bit          ee;
    for (int o = 0; o <= 32'h2C; o += 4) begin
      do_read(BASE + 32'(o), d, r);
      exp_read(32'(o), ed, ee);
      chk(d == ed, $sformatf("%s read data @%0h", tag, o), 64'(d), 64'(ed));
      chk(r == (ee ? 2'b10 : 2'b00), $sformatf("%s read resp @%0h", tag, o), 64'(r), ee ? 2 : 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [1:0]  r;
    m_cmd = '0; m_cfg = 32'h0000_CAFE; m_ctl = 32'h1; m_wout = '0;
    m_status = 32'h5A5A_0F0F; m_win = 64'h0123_4567_89AB_CDEF;
    repeat (6) @(negedge clk);
    rst = 1'b0; mod_rst = 1'b0;
    status_in = m_status; wide_in = m_win;
    repeat (20) @(negedge clk);

    // R1 reset state at the module-domain outputs and on the bus
    chk(cfg_out == 32'h0000_CAFE, "R1 cfg_out reset", 64'(cfg_out), 64'h0000_CAFE);
    chk({ctl_mask, ctl_mode, ctl_en} == 7'h01, "R1 ctl reset", 64'({ctl_mask, ctl_mode, ctl_en}), 1);
    chk(cmd_out == 0 && wide_out == 0, "R1 cmd/wide reset", {cmd_out, wide_out[31:0]}, 0);
    sweep("R1/R7 reset map");

    // R4 byte lanes on the configuration word, address first
    do_write(BASE + 32'h08, 32'h1234_5678, 4'hF, 0, r);
    apply_write(32'h08, 32'h1234_5678, 4'hF);
    chk(r == 2'b00, "R4 cfg write resp", 64'(r), 0);
    chk(w_cfg1 && !w_cmd1 && !w_cfg2, "R5 cfg write strobe one cycle",
        {w_cfg1, w_cmd1, w_cfg2}, 3'b100);
    chk(cfg_out == 32'h0000_CAFE, "R11 cfg_out not yet crossed", 64'(cfg_out), 64'h0000_CAFE);
    repeat (20) @(negedge clk);
    chk(cfg_out == 32'h1234_5678, "R11 cfg_out crossed", 64'(cfg_out), 64'h1234_5678);
    do_write(BASE + 32'h08, 32'hAABB_CCDD, 4'b0010, 1, r);
    apply_write(32'h08, 32'hAABB_CCDD, 4'b0010);
    do_read(BASE + 32'h08, d, r);
    chk(d == 32'h1234_CC78, "R4 partial strobe merge", 64'(d), 64'h1234_CC78);
    chk(r_cfg1 && !r_st1 && !r_cfg2, "R5 cfg read strobe one cycle", {r_cfg1, r_st1, r_cfg2}, 3'b100);

    // R3 command word, both channels together
    do_write(BASE + 32'h04, 32'hDEAD_BEEF, 4'hF, 2, r);
    apply_write(32'h04, 32'hDEAD_BEEF, 4'hF);
    chk(w_cmd1 && !w_cfg1 && !w_cmd2, "R5 cmd write strobe one cycle", {w_cmd1, w_cfg1, w_cmd2}, 3'b100);
    do_read(BASE + 32'h04, d, r);
    chk(d == 0 && r == 2'b00, "R3 write-only reads zero OKAY", {r, d}, 0);
    chk(!r_cfg1 && !r_st1, "R5 no read strobe on cmd", {r_cfg1, r_st1}, 0);
    repeat (20) @(negedge clk);
    chk(cmd_out == 32'hDEAD_BEEF, "R3 cmd_out", 64'(cmd_out), 64'hDEAD_BEEF);

    // R6 packed control word
    do_write(BASE + 32'h0C, 32'hFFFF_FFFF, 4'hF, 0, r);
    apply_write(32'h0C, 32'hFFFF_FFFF, 4'hF);
    do_read(BASE + 32'h0C, d, r);
    chk(d == 32'h0000_00F7, "R6 reserved bits read zero", 64'(d), 64'hF7);
    do_write(BASE + 32'h0C, 32'hFFFF_FF54, 4'b0001, 1, r);
    apply_write(32'h0C, 32'hFFFF_FF54, 4'b0001);
    do_read(BASE + 32'h0C, d, r);
    chk(d == 32'h0000_0054, "R6 field update", 64'(d), 64'h54);
    repeat (20) @(negedge clk);
    chk(!ctl_en && ctl_mode == 2'd2 && ctl_mask == 4'd5, "R6 field outputs",
        64'({ctl_mask, ctl_mode, ctl_en}), 64'({4'd5, 2'd2, 1'b0}));

    // R2 write to read-only status is inert
    do_write(BASE + 32'h00, 32'hFFFF_FFFF, 4'hF, 2, r);
    chk(r == 2'b00, "R2 RO write OKAY", 64'(r), 0);
    chk(!w_cmd1 && !w_cfg1, "R5 no write strobe on RO", {w_cmd1, w_cfg1}, 0);
    do_read(BASE + 32'h00, d, r);
    chk(d == m_status, "R2 status unchanged", 64'(d), 64'(m_status));
    chk(r_st1 && !r_cfg1 && !r_st2, "R5 status read strobe", {r_st1, r_cfg1, r_st2}, 3'b100);

    // R11 status crossing into the bus clock
    m_status = 32'h0F1E_2D3C;
    status_in = m_status;
    do_read(BASE + 32'h00, d, r);
    chk(d == 32'h5A5A_0F0F, "R11 status not yet crossed", 64'(d), 64'h5A5A_0F0F);
    repeat (10) @(negedge clk);
    do_read(BASE + 32'h00, d, r);
    chk(d == m_status, "R11 status crossed", 64'(d), 64'(m_status));

    // R7 wide read-write words
    do_write(BASE + 32'h18, 32'h1111_2222, 4'hF, 0, r);
    apply_write(32'h18, 32'h1111_2222, 4'hF);
    do_write(BASE + 32'h1C, 32'h3333_4444, 4'b1100, 1, r);
    apply_write(32'h1C, 32'h3333_4444, 4'b1100);
    repeat (20) @(negedge clk);
    chk(wide_out == m_wout, "R7 wide_out words", wide_out, m_wout);

    // R8 rejected addresses
    for (int k = 0; k < 4; k++) begin
      logic [31:0] a;
      a = (k == 0) ? BASE - 32'h4 : (k == 1) ? BASE + 32'h20 :
          (k == 2) ? BASE + 32'h1_0008 : BASE + 32'h9;
      do_write(a, 32'h0BAD_0BAD, 4'hF, k % 3, r);
      chk(r == 2'b10, $sformatf("R8 write SLVERR @%h", a), 64'(r), 2);
      do_read(a, d, r);
      chk(r == 2'b10 && d == 0, $sformatf("R8 read SLVERR zero @%h", a), {r, d}, {2'b10, 32'h0});
    end
    sweep("R8/R4/R7 map after writes");

    repeat (20) @(negedge clk);
    chk(cfg_out == m_cfg && cmd_out == m_cmd, "R8 outputs unchanged", {cfg_out, cmd_out}, {m_cfg, m_cmd});

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule